// File: doc/BRIEF.md
# Interrupt Pending and Mask Register Bank

This block is a small bank of 32-bit registers reached through a single-cycle request port (valid, write, address, write data) with combinational read data. Four of its word addresses carry interrupt meaning, and each of those addresses is a module parameter.

The first is a pending word, which hardware events and software writes can only set. The second is a clear strobe, which drops pending bits where a one is written. The third is an enable mask. The fourth is a computed status view, the AND of pending and mask, which has no storage behind it.

All other addresses are ordinary storage words. A single level interrupt output is high whenever any enabled pending bit is set. Software uses the status view to find the cause, writes ones to the clear address to acknowledge, and may write ones to the pending address to inject a test interrupt.

Top module: `irq_reg_bank`

## Requirements
- R1: A synchronous active-high reset clears every word of the bank, including pending and mask, so every address then reads zero and the interrupt output is low.
- R2: A write to the pending address ORs the write data into the pending bits; bits written as zero keep their value.
- R3: A write to the clear address drops each pending bit whose write-data bit is one and leaves the other pending bits as they were.
- R4: A read of the status address returns pending AND mask.
- R5: A write to the mask address stores the write data, and the interrupt output follows the new mask from the clock edge that takes the write.
- R6: The interrupt output is high exactly when pending AND mask is nonzero.
- R7: A write to the status address changes neither the pending bits nor the mask.
- R8: Every bit set in the 32-bit hardware event input sets the matching pending bit at the next clock edge. When an event bit and a clear bit hit the same position in one cycle, the pending bit ends up set.
- R9: Every address that is not one of the four interrupt addresses stores the written word and returns it on a later read.
- R10: A read of the clear address returns zero, and a read of the pending address returns the pending bits with no masking.
- R11: Read data is zero in any cycle without a read request (valid low, or valid with write high). Writes take effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | ADDR_W (4) | Word address |
| req_wdata | input | 32 | Write data |
| hw_event | input | 32 | Hardware event bits that set pending bits |
| rd_data | output | 32 | Combinational read data |
| irq_out | output | 1 | Level interrupt, high when an enabled bit is pending |

## Verification
On every cycle, the assertions check the following behaviours:
- Software set, clear and mask writes land as specified one edge later.
- Event bits are never lost, including when a clear hits the same bit.
- Pending bits hold still when nothing touches them.
- Whenever the status address is read, the interrupt output agrees with the status readback.

Only the bench's scenarios can show the remaining behaviours:
- The whole bank returns to zero at reset.
- Writes to the status address are ignored.
- The clear address reads as zero.
- The plain storage words keep their data.
- Idle and write cycles return zero read data.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        SEL_PLAIN = 3'd0,
        SEL_RAW   = 3'd1,
        SEL_CLR   = 3'd2,
        SEL_MASK  = 3'd3,
        SEL_STAT  = 3'd4
    } sel_e;

    typedef struct packed {
        logic rd;
        logic wr;
        sel_e sel;
    } access_t;

    // Map a word address onto its role in the bank.
    function automatic sel_e classify(
        input int unsigned a,
        input int unsigned raw_a,
        input int unsigned clr_a,
        input int unsigned mask_a,
        input int unsigned stat_a
    );
        if (a == raw_a)       return SEL_RAW;
        else if (a == clr_a)  return SEL_CLR;
        else if (a == mask_a) return SEL_MASK;
        else if (a == stat_a) return SEL_STAT;
        else                  return SEL_PLAIN;
    endfunction

endpackage

// File: rtl/irq_pending_core.sv
module irq_pending_core
    import irq_bank_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t sw_set,
    input  word_t sw_clr,
    input  logic  mask_we,
    input  word_t mask_wdata,
    input  word_t hw_event,
    output word_t raw_q,
    output word_t mask_q
);

    word_t set_bits;
    word_t raw_d;

    always_comb begin
        set_bits = sw_set | hw_event;
        // clear first, then set: an event in the same cycle survives
        raw_d    = (raw_q & ~sw_clr) | set_bits;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q <= raw_d;
            if (mask_we) begin
                mask_q <= mask_wdata;
            end
        end
    end

    // R2: software set bits are present after the edge
    a_r2_sw_set_sticks: assert property (@(posedge clk) disable iff (rst)
        (sw_set != '0) |=> ((raw_q & $past(sw_set)) == $past(sw_set)));

    // R3: cleared bits not re-raised by an event are gone after the edge
    a_r3_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (sw_clr != '0) |=> ((raw_q & $past(sw_clr & ~sw_set & ~hw_event)) == '0));

    // R8: event bits always land, even against a clear
    a_r8_event_wins: assert property (@(posedge clk) disable iff (rst)
        (hw_event != '0) |=> ((raw_q & $past(hw_event)) == $past(hw_event)));

    // R5: mask takes the written value
    a_r5_mask_store: assert property (@(posedge clk) disable iff (rst)
        mask_we |=> (mask_q == $past(mask_wdata)));

    // R7: with no set, clear or event the pending bits hold
    a_r7_pending_holds: assert property (@(posedge clk) disable iff (rst)
        ((sw_set == '0) && (sw_clr == '0) && (hw_event == '0)) |=> $stable(raw_q));

endmodule

// File: rtl/irq_word_store.sv
module irq_word_store
    import irq_bank_pkg::*;
#(
    parameter int unsigned NUM_WORDS = 16,
    localparam int unsigned ADDR_W = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  word_t             wdata,
    input  logic [ADDR_W-1:0] raddr,
    output word_t             rdata
);

    word_t words [NUM_WORDS];

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words[i] <= '0;
            end else if (we && (32'(waddr) == i)) begin
                words[i] <= wdata;
            end
        end
    end

    assign rdata = words[raddr];

endmodule

// File: rtl/irq_reg_bank.sv
module irq_reg_bank
    import irq_bank_pkg::*;
#(
    parameter int unsigned NUM_WORDS = 16,
    parameter int unsigned RAW_ADDR  = 0,
    parameter int unsigned CLR_ADDR  = 1,
    parameter int unsigned MASK_ADDR = 2,
    parameter int unsigned STAT_ADDR = 3,
    localparam int unsigned ADDR_W = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [31:0]       hw_event,
    output logic [31:0]       rd_data,
    output logic              irq_out
);

    access_t acc;
    word_t   sw_set, sw_clr, raw_q, mask_q, store_rdata;
    logic    mask_we, store_we;

    always_comb begin
        acc.rd  = req_valid & ~req_write;
        acc.wr  = req_valid & req_write;
        acc.sel = classify(32'(req_addr), RAW_ADDR, CLR_ADDR, MASK_ADDR, STAT_ADDR);
    end

    always_comb begin
        sw_set   = (acc.wr && acc.sel == SEL_RAW)  ? req_wdata : '0;
        sw_clr   = (acc.wr && acc.sel == SEL_CLR)  ? req_wdata : '0;
        mask_we  = acc.wr && (acc.sel == SEL_MASK);
        store_we = acc.wr && (acc.sel == SEL_PLAIN);
    end

    irq_pending_core u_core (
        .clk        (clk),
        .rst        (rst),
        .sw_set     (sw_set),
        .sw_clr     (sw_clr),
        .mask_we    (mask_we),
        .mask_wdata (req_wdata),
        .hw_event   (hw_event),
        .raw_q      (raw_q),
        .mask_q     (mask_q)
    );

    irq_word_store #(.NUM_WORDS(NUM_WORDS)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (store_we),
        .waddr (req_addr),
        .wdata (req_wdata),
        .raddr (req_addr),
        .rdata (store_rdata)
    );

    always_comb begin
        rd_data = '0;
        if (acc.rd) begin
            unique case (acc.sel)
                SEL_RAW:  rd_data = raw_q;
                SEL_CLR:  rd_data = '0;
                SEL_MASK: rd_data = mask_q;
                SEL_STAT: rd_data = raw_q & mask_q;
                default:  rd_data = store_rdata;
            endcase
        end
    end

    assign irq_out = |(raw_q & mask_q);

    // R1: interrupt is low right after reset
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq_out);

    // R6: interrupt level agrees with status readback
    a_r6_irq_vs_status: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && 32'(req_addr) == STAT_ADDR) |-> (irq_out == (rd_data != '0)));

endmodule

// File: tb/tb_irq_reg_bank.sv
module tb_irq_reg_bank;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write;
    logic [3:0]  req_addr;
    logic [31:0] req_wdata, hw_event, rd_data;
    logic        irq_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_reg_bank dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .hw_event(hw_event),
        .rd_data(rd_data), .irq_out(irq_out)
    );

    // addresses: pending 0, clear 1, mask 2, status 3, plain storage 4..15
    typedef struct packed {
        logic        wr;     // 1: write cycle, 0: idle cycle
        logic [3:0]  a;
        logic [31:0] d;
        logic [31:0] ev;
        logic [3:0]  ca;     // address read back afterwards
        logic [31:0] exp;
        logic        eirq;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'd0, 32'h0000_00F0, 32'h0, 4'd0, 32'h0000_00F0, 1'b0, 4'd2},  // R2
        '{1'b1, 4'd0, 32'h0000_000F, 32'h0, 4'd0, 32'h0000_00FF, 1'b0, 4'd2},  // R2 OR
        '{1'b1, 4'd2, 32'h0000_0011, 32'h0, 4'd3, 32'h0000_0011, 1'b1, 4'd5},  // R5 R4
        '{1'b1, 4'd1, 32'h0000_0001, 32'h0, 4'd0, 32'h0000_00FE, 1'b1, 4'd3},  // R3
        '{1'b1, 4'd1, 32'h0000_0010, 32'h0, 4'd3, 32'h0000_0000, 1'b0, 4'd6},  // R3 R6
        '{1'b1, 4'd3, 32'hFFFF_FFFF, 32'h0, 4'd0, 32'h0000_00EE, 1'b0, 4'd7},  // R7
        '{1'b0, 4'd0, 32'h0,         32'h0, 4'd2, 32'h0000_0011, 1'b0, 4'd7},  // R7 mask
        '{1'b1, 4'd1, 32'hFFFF_FFFF, 32'h0, 4'd0, 32'h0000_0000, 1'b0, 4'd3},  // R3
        '{1'b0, 4'd0, 32'h0,  32'h8000_0001, 4'd0, 32'h8000_0001, 1'b1, 4'd8}, // R8
        '{1'b1, 4'd1, 32'h1,  32'h0000_0001, 4'd0, 32'h8000_0001, 1'b1, 4'd8}, // R8 set wins
        '{1'b1, 4'd2, 32'h0,         32'h0, 4'd3, 32'h0000_0000, 1'b0, 4'd5},  // R5 unmask
        '{1'b1, 4'd5, 32'hDEAD_BEEF, 32'h0, 4'd5, 32'hDEAD_BEEF, 1'b0, 4'd9},  // R9
        '{1'b1, 4'd15, 32'h1234_5678, 32'h0, 4'd15, 32'h1234_5678, 1'b0, 4'd9}, // R9
        '{1'b0, 4'd0, 32'h0,         32'h0, 4'd1, 32'h0000_0000, 1'b0, 4'd10}, // R10
        '{1'b1, 4'd2, 32'h8000_0000, 32'h0, 4'd3, 32'h8000_0000, 1'b1, 4'd4},  // R4 R6
        '{1'b1, 4'd0, 32'h0,         32'h0, 4'd0, 32'h8000_0001, 1'b1, 4'd10}  // R10 R2
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // read at the current negedge, sample combinationally
    task automatic read_word(input logic [3:0] a, output logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; hw_event = '0;
        #1;
        d = rd_data;
    endtask

    task automatic idle();
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; hw_event = '0;
    endtask

    initial begin
        logic [31:0] got;
        idle();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        read_word(4'd0, got);  check("R1 pending", got, 32'h0);
        check("R1 irq", {31'b0, irq_out}, 32'h0);
        read_word(4'd7, got);  check("R1 storage", got, 32'h0);
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            req_valid = VECS[i].wr; req_write = VECS[i].wr;
            req_addr = VECS[i].a; req_wdata = VECS[i].d; hw_event = VECS[i].ev;
            @(negedge clk);
            read_word(VECS[i].ca, got);
            check($sformatf("R%0d vec%0d data", VECS[i].req, i), got, VECS[i].exp);
            check($sformatf("R6 vec%0d irq", i), {31'b0, irq_out}, {31'b0, VECS[i].eirq});
            @(negedge clk);
        end

        // R11: no read data while idle or writing
        idle(); #1;
        check("R11 idle", rd_data, 32'h0);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 4'd5; req_wdata = 32'h0000_0042; #1;
        check("R11 write", rd_data, 32'h0);
        @(negedge clk);
        read_word(4'd5, got); check("R11 write landed at edge", got, 32'h0000_0042);
        @(negedge clk);

        // R1: reset in the middle of activity
        idle(); rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        read_word(4'd5, got); check("R1 storage after reset", got, 32'h0);
        read_word(4'd0, got); check("R1 pending after reset", got, 32'h0);
        read_word(4'd2, got); check("R1 mask after reset", got, 32'h0);
        check("R1 irq after reset", {31'b0, irq_out}, 32'h0);
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 20000);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule